// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This core holds the per-pin state of a general-purpose port expander with `NUM_PINS` pins, where the pin count is a power of two no smaller than 8. The pins are split into banks of eight. A host reaches the state one byte at a time through a plain read/write strobe interface: each access names one register address and moves one byte. The core drives output levels and output enables toward the pads, and passes the pad inputs through a synchronizer. It latches a sticky change flag for every input pin and raises a single interrupt line toward the host.

The address map scales with the pin count. With `E = log2(NUM_PINS) - 3` and `2^E` banks, register group `g` of bank `b` sits at address `(g << E) + b`. Five group codes are decoded: direction, level, interrupt enable, change status, and a reserved group. A host changes a single pin by reading the bank's level byte, modifying it and writing it back. The host treats the interrupt line as a rising-edge request.

Top module: `gpx_core`

## Requirements
- R1: After reset every direction bit, enable bit and status bit is 0, so `pin_oe` is all zero and `irq` is low.
- R2: Group g of bank b is at address `(g << E) + b`, with `E = log2(NUM_PINS) - 3`. The group codes are direction g=0, level g=1, enable g=2, status g=3 and reserved g=4. Pin p lives in bit `p mod 8` of bank `p / 8`.
- R3: Writing the direction byte of a bank stores it. A 1 bit makes the pin an output (`pin_oe` bit high) and a 0 bit makes it an input. Reading the direction byte returns the stored value.
- R4: Writing the level byte of a bank sets that bank's output latch, and `pin_out` follows it after the write edge.
- R5: `rdata` is registered and is valid from the clock edge that samples `rd_en`. A level read returns the latch bit for an output pin and the synchronized pad bit for an input pin.
- R6: A change of the synchronized level of an input pin sets that pin's status bit. The bit is visible at the ports within three clock edges after the edge that first samples the new pad value. A change on a pin whose direction bit is 1 sets nothing.
- R7: A status read returns the status byte ANDed with the enable byte. The read clears the whole status byte of that bank, masked bits included. A change arriving at the same edge as the clear is kept.
- R8: `irq` is high exactly while some bank has a bit set in (status AND enable).
- R9: The reserved group, and the unused group codes 5 to 7, read as 0 and ignore writes.
- R10: Writes to the status group have no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte at `addr` |
| rd_en | input | 1 | Read strobe for one byte at `addr` |
| addr | input | E+3 | Register address `(group << E) + bank` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pin_in | input | NUM_PINS | Raw pad input levels |
| pin_out | output | NUM_PINS | Output level latches |
| pin_oe | output | NUM_PINS | Output enables, copied from the direction bits |
| irq | output | 1 | Interrupt request toward the host |

## Verification
A corrupted direction or level latch shows up on `pin_oe` or `pin_out` one edge after the write, and on the next read of that byte. A decode slip that puts a byte in the wrong bank shows as a disturbed neighbour slice. A stale change-detect register or a missing clear leaves `irq` high, or returns a nonzero status byte, on the first read after the clear. A wrong input mask raises `irq` for an output pin within three edges of the pad change.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   localparam int GRP_W  = 3;
   localparam int BYTE_W = 8;

   typedef enum logic [GRP_W-1:0] {
      GRP_DIR = 3'd0,
      GRP_LVL = 3'd1,
      GRP_IEN = 3'd2,
      GRP_IST = 3'd3,
      GRP_RSV = 3'd4
   } gpx_grp_e;

   function automatic int bank_exp(input int pins);
      return $clog2(pins) - 3;
   endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   initial begin
      assert (STAGES >= 2) else $error("gpx_sync: STAGES must be at least 2");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] pad_i,
   input  logic       wr_dir_i,
   input  logic       wr_lvl_i,
   input  logic       wr_ien_i,
   input  logic       rd_ist_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] dir_o,
   output logic [7:0] out_o,
   output logic [7:0] ien_o,
   output logic [7:0] level_o,
   output logic [7:0] ist_o,
   output logic       irq_o
);

   logic [7:0] dir_q, out_q, ien_q, stat_q, last_q;
   logic [7:0] sync_lvl, set_v;

   gpx_sync #(.WIDTH(8), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_i),
      .q_o   (sync_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         ien_q <= '0;
      end else begin
         if (wr_dir_i) dir_q <= wdata_i;
         if (wr_lvl_i) out_q <= wdata_i;
         if (wr_ien_i) ien_q <= wdata_i;
      end
   end

   // change detect on input pins only
   assign set_v = (sync_lvl ^ last_q) & ~dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= '0;
         stat_q <= '0;
      end else begin
         last_q <= sync_lvl;
         stat_q <= (stat_q & ~{8{rd_ist_i}}) | set_v;
      end
   end

   assign dir_o   = dir_q;
   assign out_o   = out_q;
   assign ien_o   = ien_q;
   assign level_o = (dir_q & out_q) | (~dir_q & sync_lvl);
   assign ist_o   = stat_q & ien_q;
   assign irq_o   = |ist_o;

   // R3: a direction write lands in the latch
   a_r3_dir_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_i |=> dir_q == $past(wdata_i));

   // R4: a level write lands in the output latch
   a_r4_lvl_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lvl_i |=> out_q == $past(wdata_i));

   // R6: a detected change is latched
   a_r6_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> (stat_q & $past(set_v)) == $past(set_v));

   // R7: a read with no new change leaves the byte clear
   a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ist_i && set_v == 8'h00) |=> stat_q == 8'h00);

   // R10: no status bit appears without a change
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v == 8'h00) |=> (stat_q & ~$past(stat_q)) == 8'h00);

endmodule

// File: rtl/gpx_core.sv
module gpx_core
   import gpx_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int EXP        = bank_exp(NUM_PINS),
   localparam int BANKS      = 1 << EXP,
   localparam int AW         = EXP + GRP_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [AW-1:0]       addr,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);

   initial begin
      assert (NUM_PINS >= 8 && (NUM_PINS & (NUM_PINS - 1)) == 0)
         else $error("gpx_core: NUM_PINS must be a power of two of at least 8");
   end

   logic [GRP_W-1:0] grp;
   logic [AW-1:0]    bank_idx;
   logic [7:0]       dir_b [BANKS];
   logic [7:0]       out_b [BANKS];
   logic [7:0]       ien_b [BANKS];
   logic [7:0]       lvl_b [BANKS];
   logic [7:0]       ist_b [BANKS];
   logic [BANKS-1:0] irq_b;
   logic [BANKS-1:0] rd_ist_b;
   logic [7:0]       rd_byte;
   logic [7:0]       rdata_q;

   assign grp      = GRP_W'(addr >> EXP);
   assign bank_idx = addr & AW'(BANKS - 1);

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic sel;
         assign sel         = (bank_idx == AW'(b));
         assign rd_ist_b[b] = rd_en && sel && (grp == GRP_IST);

         gpx_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_i    (pin_in[8*b +: 8]),
            .wr_dir_i (wr_en && sel && (grp == GRP_DIR)),
            .wr_lvl_i (wr_en && sel && (grp == GRP_LVL)),
            .wr_ien_i (wr_en && sel && (grp == GRP_IEN)),
            .rd_ist_i (rd_ist_b[b]),
            .wdata_i  (wdata),
            .dir_o    (dir_b[b]),
            .out_o    (out_b[b]),
            .ien_o    (ien_b[b]),
            .level_o  (lvl_b[b]),
            .ist_o    (ist_b[b]),
            .irq_o    (irq_b[b])
         );

         assign pin_out[8*b +: 8] = out_b[b];
         assign pin_oe[8*b +: 8]  = dir_b[b];
      end
   endgenerate

   always_comb begin
      rd_byte = 8'h00;
      for (int b = 0; b < BANKS; b++) begin
         if (bank_idx == AW'(b)) begin
            case (grp)
               GRP_DIR: rd_byte = dir_b[b];
               GRP_LVL: rd_byte = lvl_b[b];
               GRP_IEN: rd_byte = ien_b[b];
               GRP_IST: rd_byte = ist_b[b];
               default: rd_byte = 8'h00;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= 8'h00;
      else if (rd_en) rdata_q <= rd_byte;
   end

   assign rdata = rdata_q;
   assign irq   = |irq_b;

   // R1: state leaving reset is quiet
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && irq == 1'b0));

   // R9: reserved and unused groups read as zero
   a_r9_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && grp >= GRP_W'(GRP_RSV)) |=> rdata == 8'h00);

   // R7: at most one bank's status is cleared per read
   a_r7_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_ist_b));

endmodule

// File: tb/gpx_core_bench.sv
module gpx_core_bench;

   localparam int NP  = 16;
   localparam int EXP = 1;
   localparam int NB  = 2;
   localparam int AW  = EXP + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   gpx_core #(.NUM_PINS(NP)) u_gpx_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   function automatic logic [AW-1:0] ra(input int g, input int b);
      return AW'((g << EXP) + b);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_oe", 32'(pin_oe), 0);
      chk("R1 irq", 32'(irq), 0);
      for (int b = 0; b < NB; b++) begin
         rd(ra(0, b), d); chk("R1 dir", 32'(d), 0);
         rd(ra(2, b), d); chk("R1 ien", 32'(d), 0);
         rd(ra(3, b), d); chk("R1 ist", 32'(d), 0);
      end

      // R2 R3 direction sweep per bank
      for (int b = 0; b < NB; b++) begin
         for (int v = 0; v < 256; v++) begin
            wr(ra(0, b), 8'(v));
            chk("R3 pin_oe", 32'(pin_oe), 32'(v << (8 * b)));
            rd(ra(0, b), d);
            chk("R2 dir readback", 32'(d), 32'(v));
         end
         wr(ra(0, b), 8'h00);
      end

      // R4 R5 level sweep with all outputs
      wr(ra(0, 0), 8'hFF);
      wr(ra(0, 1), 8'hFF);
      for (int b = 0; b < NB; b++) begin
         for (int v = 0; v < 256; v++) begin
            wr(ra(1, b), 8'(v));
            chk("R4 pin_out", 32'(pin_out[8*b +: 8]), 32'(v));
            rd(ra(1, b), d);
            chk("R5 level out", 32'(d), 32'(v));
         end
      end
      chk("R4 pin_out other bank", 32'(pin_out), 32'hFFFF);

      // R2 enable sweep
      for (int b = 0; b < NB; b++) begin
         for (int v = 0; v < 256; v++) begin
            wr(ra(2, b), 8'(v));
            rd(ra(2, b), d);
            chk("R2 ien readback", 32'(d), 32'(v));
         end
         wr(ra(2, b), 8'h00);
      end

      // R5 input levels
      wr(ra(0, 0), 8'h00);
      wr(ra(0, 1), 8'h00);
      for (int k = 0; k < 16; k++) begin
         pin_in = 16'(k * 16'h1357 + 16'h00A5);
         settle();
         rd(ra(1, 0), d); chk("R5 level in b0", 32'(d), 32'(pin_in[7:0]));
         rd(ra(1, 1), d); chk("R5 level in b1", 32'(d), 32'(pin_in[15:8]));
         chk("R8 irq masked", 32'(irq), 0);
      end
      // mixed direction
      wr(ra(0, 0), 8'hF0);
      wr(ra(1, 0), 8'h3C);
      rd(ra(1, 0), d);
      chk("R5 level mixed", 32'(d), 32'((8'h3C & 8'hF0) | (pin_in[7:0] & 8'h0F)));
      wr(ra(0, 0), 8'h00);

      // flush status
      rd(ra(3, 0), d);
      rd(ra(3, 1), d);

      // R6 R7 R8 masking and clear
      wr(ra(2, 0), 8'h0F);
      chk("R8 irq idle", 32'(irq), 0);
      pin_in = pin_in ^ 16'h0011;
      settle();
      chk("R8 irq set", 32'(irq), 1);
      rd(ra(3, 0), d);
      chk("R7 masked status", 32'(d), 32'h01);
      chk("R8 irq after clear", 32'(irq), 0);
      wr(ra(2, 0), 8'hFF);
      rd(ra(3, 0), d);
      chk("R7 whole byte cleared", 32'(d), 0);
      chk("R8 irq still low", 32'(irq), 0);
      pin_in = pin_in ^ 16'h0080;
      settle();
      rd(ra(3, 0), d);
      chk("R6 change bit7", 32'(d), 32'h80);

      // R6 output pins set nothing
      wr(ra(0, 1), 8'hFF);
      wr(ra(2, 1), 8'hFF);
      pin_in = pin_in ^ 16'hFF00;
      settle();
      chk("R6 irq output pins", 32'(irq), 0);
      rd(ra(3, 1), d);
      chk("R6 status output pins", 32'(d), 0);

      // R9 reserved and unused groups
      for (int g = 4; g < 8; g++) begin
         for (int b = 0; b < NB; b++) begin
            wr(ra(g, b), 8'hFF);
            rd(ra(g, b), d);
            chk("R9 reserved read", 32'(d), 0);
         end
      end
      rd(ra(0, 0), d); chk("R9 dir untouched", 32'(d), 0);
      rd(ra(0, 1), d); chk("R9 dir1 untouched", 32'(d), 32'hFF);
      rd(ra(2, 0), d); chk("R9 ien untouched", 32'(d), 32'hFF);

      // R10 status writes ignored
      wr(ra(3, 0), 8'hFF);
      wr(ra(3, 1), 8'hFF);
      chk("R10 irq", 32'(irq), 0);
      rd(ra(3, 0), d); chk("R10 status b0", 32'(d), 0);
      rd(ra(3, 1), d); chk("R10 status b1", 32'(d), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule